// File: doc/BRIEF.md
# Interlaced Field Parity Detector

This block tells the two fields of an interlaced video frame apart. It watches a sampled composite sync stream (active high while a sync pulse is present) and a vertical pulse supplied by a separate vertical detector. It produces one output bit: high while the odd field is being received and low during the even field.

A gap counter measures how long sync stays deasserted. A parity flop flips on the leading edge of every sync pulse. Any gap longer than a programmable limit clears the flop. A full scan line clears it, but the half-line gaps around vertical retrace do not. So when the vertical pulse arrives, the flop holds the parity of the half-line gaps seen since the last full line. The odd field ends with one extra half line, so its parity differs from the even field's.

The limit is given in clock cycles on an input port. It should sit between the half-line and full-line durations, for example near three quarters of a line. The field bit is loaded on the rising edge of the vertical pulse and holds until the next one.

Top module: `field_det`

## Requirements
- R1: While rst_n is low, field_odd_o is 0 and the parity flop is cleared.
- R2: Each leading (0 to 1) edge of sync_i inverts the parity flop exactly once, however long sync_i then stays high.
- R3: A run of consecutive low samples of sync_i longer than gap_limit_i cycles clears the parity flop. A run of exactly gap_limit_i cycles leaves it unchanged. The gap counter saturates at all ones rather than wrapping.
- R4: On a rising edge of vsync_i, field_odd_o is loaded with the parity flop: 1 when an odd number of sync leading edges has occurred since the last clearing gap. sync_i and vsync_i pass through equal sampling delays. A sync leading edge sampled in the same cycle as the vsync rising edge is not included in the loaded value.
- R5: Between rising edges of vsync_i, field_odd_o holds its value. Neither sync activity, nor vsync_i staying high, nor a falling edge of vsync_i changes it.
- R6: gap_limit_i may change at run time between pulses. Gaps that follow the change are judged against the new value.
- R7: For an interlaced sync pattern, field_odd_o is 0 when the vertical pulse follows an even number of half-line sync periods. It is 1 when a trailing half line adds one more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sync_i | input | 1 | Composite sync, 1 while a sync pulse is present |
| vsync_i | input | 1 | Vertical pulse from the vertical detector |
| gap_limit_i | input | CNT_W | Gap length in cycles above which a gap counts as a full line |
| field_odd_o | output | 1 | Field index: 1 odd field, 0 even field |

## Verification
A parity flop that misses a toggle or a clear would stay hidden until the next vertical rising edge. At that edge the field bit comes out inverted and stays wrong for the whole field, roughly two clock cycles after vsync_i is sampled. A gap counter that wraps or compares off by one would show up only at the boundary between a gap of exactly the limit and one cycle more. The bench therefore places gaps on both sides of that boundary and follows each with a vertical edge. A capture register that loads on the wrong edge would change the field bit in mid-field, so the bench re-checks the output while vsync_i is held high and after it falls.

// File: rtl/field_det_pkg.sv
package field_det_pkg;
  // index of each input lane in the shared sampling stage
  localparam int LANE_SYNC = 0;
  localparam int LANE_VERT = 1;
  localparam int LANES     = 2;

  typedef struct packed {
    logic lvl;
    logic rise;
  } lane_t;
endpackage

// File: rtl/field_det_edge.sv
module field_det_edge
  import field_det_pkg::*;
#(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output lane_t        lane_o [N]
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_lane
      logic s1_q, s2_q;
      logic s1_d, s2_d;

      always_comb begin
        s1_d = din[g];
        s2_d = s1_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_q <= 1'b0;
          s2_q <= 1'b0;
        end else begin
          s1_q <= s1_d;
          s2_q <= s2_d;
        end
      end

      always_comb begin
        lane_o[g].lvl  = s1_q;
        lane_o[g].rise = s1_q & ~s2_q;
      end
    end
  endgenerate
endmodule

// File: rtl/field_det_gap.sv
module field_det_gap #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_lvl_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = sync_lvl_i | (cnt_q != CNT_MAX);
    if (sync_lvl_i) cnt_d = '0;
    else            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    cnt_o = cnt_q;
    hit_o = ~sync_lvl_i & (cnt_q >= limit_i);
  end
endmodule

// File: rtl/field_det_flop.sv
module field_det_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q, q_d, q_en;

  always_comb begin
    q_en = tog_i | clr_i;
    if (clr_i) q_d = 1'b0;
    else       q_d = ~q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= 1'b0;
    else if (q_en) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/field_det.sv
module field_det
  import field_det_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             vsync_i,
  input  logic [CNT_W-1:0] gap_limit_i,
  output logic             field_odd_o
);
  lane_t            lanes [LANES];
  logic [LANES-1:0] lane_in;
  logic             sync_lvl, sync_rise, vs_rise;
  logic             gap_hit, fld_flop;
  logic [CNT_W-1:0] gap_cnt;
  logic             idx_q, idx_d, idx_en;

  always_comb begin
    lane_in            = '0;
    lane_in[LANE_SYNC] = sync_i;
    lane_in[LANE_VERT] = vsync_i;
  end

  field_det_edge #(.N(LANES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (lane_in),
    .lane_o (lanes)
  );

  always_comb begin
    sync_lvl  = lanes[LANE_SYNC].lvl;
    sync_rise = lanes[LANE_SYNC].rise;
    vs_rise   = lanes[LANE_VERT].rise;
  end

  field_det_gap #(.CNT_W(CNT_W)) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_lvl_i (sync_lvl),
    .limit_i    (gap_limit_i),
    .cnt_o      (gap_cnt),
    .hit_o      (gap_hit)
  );

  field_det_flop u_flop (
    .clk   (clk),
    .rst_n (rst_n),
    .tog_i (sync_rise),
    .clr_i (gap_hit),
    .q_o   (fld_flop)
  );

  always_comb begin
    idx_en = vs_rise;
    idx_d  = fld_flop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= 1'b0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign field_odd_o = idx_q;
endmodule

// File: rtl/field_det_chk.sv
module field_det_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_lvl,
  input logic             sync_rise,
  input logic             vs_rise,
  input logic             gap_hit,
  input logic             fld_flop,
  input logic [CNT_W-1:0] gap_cnt,
  input logic             field_odd_o
);
  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |-> (field_odd_o == 1'b0 && fld_flop == 1'b0));

  assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rise && !gap_hit) |=> (fld_flop != $past(fld_flop)));

  assert_gap_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_hit |=> !fld_flop);

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_cnt == {CNT_W{1'b1}} && !sync_lvl) |=> (gap_cnt == {CNT_W{1'b1}}));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (field_odd_o == $past(fld_flop)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> $stable(field_odd_o));
endmodule

bind field_det field_det_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_lvl    (sync_lvl),
  .sync_rise   (sync_rise),
  .vs_rise     (vs_rise),
  .gap_hit     (gap_hit),
  .fld_flop    (fld_flop),
  .gap_cnt     (gap_cnt),
  .field_odd_o (field_odd_o)
);

// File: tb/field_det_bench.sv
module field_det_bench;
  localparam int CNT_W = 10;

  logic             clk;
  logic             rst_n;
  logic             sync_i;
  logic             vsync_i;
  logic [CNT_W-1:0] gap_limit;
  logic             field_odd_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit par    = 0;   // model of parity flop
  bit exp_idx = 0;  // model of captured field bit

  field_det #(.CNT_W(CNT_W)) u_field_det (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_i      (sync_i),
    .vsync_i     (vsync_i),
    .gap_limit_i (gap_limit),
    .field_odd_o (field_odd_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s field_odd_o actual %b expected %b", req, got, exp);
    end
  endtask

  // vm: 0 vsync low, 1 vsync rises in the gap, 2 keep vsync level, 3 vsync rises with sync
  task automatic pulse(input int h, input int l, input int vm);
    if (vm == 3) begin
      vsync_i = 1'b1;
      exp_idx = par;
    end else if (vm != 2) begin
      vsync_i = 1'b0;
    end
    sync_i = 1'b1;
    par    = ~par;
    repeat (h) @(negedge clk);
    sync_i = 1'b0;
    if (vm == 1) begin
      repeat (2) @(negedge clk);
      vsync_i = 1'b1;
      exp_idx = par;
      repeat (l - 2) @(negedge clk);
    end else begin
      repeat (l) @(negedge clk);
    end
    if (l > int'(gap_limit)) par = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b1; sync_i = 1'b0; vsync_i = 1'b0; gap_limit = 10'd30;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(field_odd_o, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(field_odd_o, 1'b0, "R1 after release");
    par = 1'b0;
  endtask

  task automatic t_parity;
    for (int n = 0; n < 4; n++) begin
      pulse(3, 37, 0);
      for (int k = 0; k < n; k++) pulse(2, 18, 0);
      pulse(2, 18, 1);
      chk(field_odd_o, exp_idx, "R4 parity model");
      chk(field_odd_o, logic'((n + 1) % 2), "R2 edge count");
    end
    pulse(3, 37, 0);
    pulse(12, 20, 1);
    chk(field_odd_o, 1'b1, "R2 long sync one toggle");
  endtask

  task automatic t_boundary;
    pulse(3, 37, 0);
    pulse(3, 30, 0);
    pulse(3, 10, 1);
    chk(field_odd_o, 1'b0, "R3 gap equal to limit keeps");
    pulse(3, 37, 0);
    pulse(3, 31, 0);
    pulse(3, 10, 1);
    chk(field_odd_o, 1'b1, "R3 gap one over limit clears");
  endtask

  task automatic t_limit;
    pulse(3, 37, 0);
    gap_limit = 10'd15;
    pulse(3, 18, 0);
    pulse(2, 10, 1);
    chk(field_odd_o, 1'b1, "R6 lower limit clears 18");
    gap_limit = 10'd30;
    pulse(3, 37, 0);
    pulse(3, 18, 0);
    pulse(2, 10, 1);
    chk(field_odd_o, 1'b0, "R6 restored limit keeps 18");
  endtask

  task automatic t_hold;
    logic held;
    pulse(3, 37, 0);
    pulse(2, 18, 1);
    held = exp_idx;
    chk(field_odd_o, held, "R5 capture");
    pulse(2, 18, 2);
    chk(field_odd_o, held, "R5 vsync held high");
    pulse(2, 18, 2);
    chk(field_odd_o, held, "R5 vsync held high 2");
    pulse(3, 37, 0);
    chk(field_odd_o, held, "R5 vsync fell");
    pulse(2, 18, 0);
    chk(field_odd_o, held, "R5 sync activity");
  endtask

  task automatic t_same_cycle;
    pulse(3, 37, 0);
    pulse(2, 18, 0);
    pulse(2, 18, 3);
    chk(field_odd_o, 1'b1, "R4 same-cycle edge excluded");
    chk(field_odd_o, exp_idx, "R4 same-cycle model");
  endtask

  task automatic t_interlace;
    for (int f = 0; f < 2; f++) begin
      repeat (4) pulse(3, 37, 0);
      repeat (5) pulse(2, 18, 0);
      pulse(2, 18, 1);
      chk(field_odd_o, 1'b0, "R7 even field");
      repeat (3) pulse(2, 18, 2);
      repeat (4) pulse(3, 37, 0);
      chk(field_odd_o, 1'b0, "R7 even field held");
      pulse(3, 18, 0);
      repeat (5) pulse(2, 18, 0);
      pulse(2, 18, 1);
      chk(field_odd_o, 1'b1, "R7 odd field");
      repeat (3) pulse(2, 18, 2);
      pulse(3, 37, 0);
      chk(field_odd_o, 1'b1, "R7 odd field held");
    end
  endtask

  initial begin
    t_reset();
    t_parity();
    t_boundary();
    t_limit();
    t_hold();
    t_same_cycle();
    t_interlace();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule